// File: doc/BRIEF.md
# Local Interrupt Take Selector

This block decides, on every clock cycle, whether a hart should take a local interrupt and, if so, which one. It receives the raw pending and enable vectors, a per-interrupt delegation mask, the global machine and supervisor interrupt-enable bits from the status register, and the hart's current privilege level. From these it forms a qualified candidate set and picks one index.

An interrupt is a candidate only if it is both pending and enabled. Non-delegated candidates are gated by a machine-level global enable. Delegated candidates are gated by a supervisor-level global enable. Each of these enables depends on the current privilege and on its own status bit. The two gated sets are merged, and the lowest set index wins. The take flag and the index are registered, so trap-entry logic downstream sees a stable decision one cycle after the inputs.

Top module: `irq_take_sel`

## Requirements
- R1: While rst_n is low at a rising edge, take_o becomes 0 and take_idx_o becomes 0 after that edge.
- R2: An interrupt whose pending bit or enable bit is 0 is never selected. When no interrupt is both pending and enabled, take_o is 0.
- R3: The machine global enable is true when priv is user (0) or supervisor (1), or when priv is machine (3) and st_mie is 1.
- R4: The supervisor global enable is true when priv is user (0), or when priv is supervisor (1) and st_sie is 1. It is false at machine level whatever st_sie is.
- R5: A candidate with irq_deleg bit 0 is gated by the machine enable, and a candidate with irq_deleg bit 1 is gated by the supervisor enable. The final set is the OR of both gated sets.
- R6: When the final set is non-zero, take_o is 1 and take_idx_o is the index of its lowest set bit. Bit 0 has the highest priority.
- R7: When the final set is zero, take_o is 0 and take_idx_o is 0.
- R8: take_o and take_idx_o reflect the inputs sampled at the previous rising edge and update on every cycle, with no hold or stall.
- R9: The privilege encoding 2 behaves exactly like machine level (3) for both global enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | 16 | Interrupt pending vector |
| irq_en | input | 16 | Interrupt enable vector |
| irq_deleg | input | 16 | Delegation mask, 1 = handled at supervisor level |
| st_mie | input | 1 | Status machine global interrupt enable |
| st_sie | input | 1 | Status supervisor global interrupt enable |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 2 or 3 machine |
| take_o | output | 1 | Registered take-interrupt flag |
| take_idx_o | output | 4 | Registered index of the interrupt to take |

## Verification
Directed cases sweep all four privilege codes against both status enable bits, with candidates that are purely delegated, purely non-delegated, or mixed. This separates a wrong machine enable from a wrong supervisor enable and shows whether encoding 2 is treated as machine. Mixed cases place a masked delegated interrupt below an open non-delegated one, so a picker that runs before the gating would choose the wrong index. Pending-without-enable and single top-bit patterns test candidate formation and the edges of the priority chain. Long runs of seeded random vectors, with one expected result per cycle, test the one-cycle latency and the per-cycle update.

// File: rtl/irq_take_sel_pkg.sv
// Package: shared types for the local interrupt take selector.
// Assumes a two-bit privilege code where both 2 and 3 mean machine.
package irq_take_sel_pkg;
    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;
endpackage

// File: rtl/irq_glob_en.sv
// Module: derives the machine and supervisor global interrupt enables.
// Assumes encoding 2 is treated as machine level.
module irq_glob_en
    import irq_take_sel_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       st_mie,
    input  logic       st_sie,
    output logic       m_en,
    output logic       s_en
);
    logic at_mach;

    // Classify the privilege level and form both enables.
    always_comb begin
        at_mach = priv[1];
        m_en    = !at_mach || st_mie;
        s_en    = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && st_sie);
    end

    // A supervisor-level enable can never be open at machine level.
    always_comb begin
        if (at_mach) begin
            AST_S_CLOSED_AT_M: assert (!s_en); // R4
        end
    end
endmodule

// File: rtl/irq_gate.sv
// Module: forms candidates (pending AND enable) and gates each bit by the
// enable that matches its delegation bit. Purely combinational.
module irq_gate #(
    parameter int N = 16
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    input  logic [N-1:0] deleg,
    input  logic         m_en,
    input  logic         s_en,
    output logic [N-1:0] ready
);
    // One gate per interrupt line.
    for (genvar g = 0; g < N; g++) begin : g_line
        assign ready[g] = pend[g] & en[g] & (deleg[g] ? s_en : m_en);
    end

    // No line may be ready unless it is pending and enabled.
    always_comb begin
        AST_READY_SUBSET: assert ((ready & ~(pend & en)) == '0); // R2
    end
endmodule

// File: rtl/irq_lsb_pick.sv
// Module: finds the lowest set bit of a vector. The index is 0 when the
// vector is empty. Assumes N is a power of two.
module irq_lsb_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] below;

    // Scan from the top so that the lowest set bit is assigned last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = i[IDX_W-1:0];
        end
        any = |vec;
    end

    // Mask of the bits below the chosen index, used only by the check.
    always_comb begin
        below = (N'(1) << idx) - N'(1);
    end

    // The chosen bit is set and no lower bit is set.
    always_comb begin
        if (any) begin
            AST_LOWEST_PICK: assert (vec[idx] && ((vec & below) == '0)); // R6
        end
    end
endmodule

// File: rtl/irq_take_sel.sv
// Module: top of the local interrupt take selector. Combinational gating
// and picking, followed by one register stage on the flag and the index.
// Synchronous active-low reset.
module irq_take_sel #(
    parameter int NUM_IRQ = 16,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic [NUM_IRQ-1:0] irq_deleg,
    input  logic               st_mie,
    input  logic               st_sie,
    input  logic [1:0]         priv,
    output logic               take_o,
    output logic [IDX_W-1:0]   take_idx_o
);
    logic               m_en;
    logic               s_en;
    logic [NUM_IRQ-1:0] ready;
    logic               any;
    logic [IDX_W-1:0]   idx;

    irq_glob_en u_glob (
        .priv   (priv),
        .st_mie (st_mie),
        .st_sie (st_sie),
        .m_en   (m_en),
        .s_en   (s_en)
    );

    irq_gate #(.N(NUM_IRQ)) u_gate (
        .pend  (irq_pend),
        .en    (irq_en),
        .deleg (irq_deleg),
        .m_en  (m_en),
        .s_en  (s_en),
        .ready (ready)
    );

    irq_lsb_pick #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
        .vec (ready),
        .any (any),
        .idx (idx)
    );

    // Register the decision every cycle; clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            take_idx_o <= '0;
        end else begin
            take_o     <= any;
            take_idx_o <= idx;
        end
    end

    AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (take_idx_o == '0)); // R7

    AST_NO_CAND_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(irq_pend & irq_en) == '0)) |-> !take_o); // R2

    AST_M_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(priv[1] && !st_mie)) |-> !take_o); // R3

    AST_USER_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(priv == 2'd0) && ($past(irq_pend & irq_en) != '0))
        |-> take_o); // R5
endmodule

// File: tb/irq_take_sel_tb_top.sv
// Bench: directed corner cases plus seeded random vectors, compared against
// a behavioural model written from the requirements.
module irq_take_sel_tb_top;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_pend = '0;
    logic [N-1:0] irq_en = '0;
    logic [N-1:0] irq_deleg = '0;
    logic         st_mie = 1'b0;
    logic         st_sie = 1'b0;
    logic [1:0]   priv = 2'd0;
    logic         take_o;
    logic [3:0]   take_idx_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    irq_take_sel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pend   (irq_pend),
        .irq_en     (irq_en),
        .irq_deleg  (irq_deleg),
        .st_mie     (st_mie),
        .st_sie     (st_sie),
        .priv       (priv),
        .take_o     (take_o),
        .take_idx_o (take_idx_o)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: cycles %0d expected < 100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [N-1:0] model_set(input logic [N-1:0] p, input logic [N-1:0] e,
                                               input logic [N-1:0] d, input logic mie,
                                               input logic sie, input logic [1:0] pv);
        logic men;
        logic sen;
        men = (pv < 2'd2) || mie;
        sen = (pv == 2'd0) || ((pv == 2'd1) && sie);
        return (p & e & ~d & {N{men}}) | (p & e & d & {N{sen}});
    endfunction

    function automatic logic [3:0] model_idx(input logic [N-1:0] s);
        for (int i = 0; i < N; i++) begin
            if (s[i]) return i[3:0];
        end
        return 4'd0;
    endfunction

    task automatic drive(input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
                         input logic mie, input logic sie, input logic [1:0] pv);
        @(negedge clk);
        irq_pend = p; irq_en = e; irq_deleg = d;
        st_mie = mie; st_sie = sie; priv = pv;
    endtask

    task automatic check(input string req, input logic et, input logic [3:0] ei);
        checks = checks + 1;
        if (take_o !== et || take_idx_o !== ei) begin
            errors = errors + 1;
            $display("FAIL %s: take=%0b idx=%0d expected take=%0b idx=%0d",
                     req, take_o, take_idx_o, et, ei);
        end
    endtask

    // Apply one vector, wait for the register edge and compare with the model.
    task automatic apply(input string req, input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [N-1:0] d, input logic mie, input logic sie,
                         input logic [1:0] pv);
        logic [N-1:0] s;
        drive(p, e, d, mie, sie, pv);
        s = model_set(p, e, d, mie, sie, pv);
        @(posedge clk);
        #2;
        check(req, |s, model_idx(s));
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset clears the outputs even with a takeable input.
        drive(16'h0001, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 2'd0);
        @(posedge clk); #2;
        check("R1", 1'b0, 4'd0);
        @(posedge clk); #2;
        check("R1", 1'b0, 4'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: pending but not enabled, and enabled but not pending.
        apply("R2", 16'h00F0, 16'h0F0F, 16'h0000, 1'b1, 1'b1, 2'd0);
        apply("R2", 16'h0000, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 2'd0);
        // R6: lowest index wins; the top bit alone is reachable.
        apply("R6", 16'hA010, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 2'd0);
        apply("R6", 16'h8000, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 2'd1);
        apply("R6", 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 2'd0);
        // R3: machine level depends on st_mie.
        apply("R3", 16'h0040, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 2'd3);
        apply("R3", 16'h0040, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 2'd3);
        apply("R3", 16'h0040, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 2'd1);
        // R4: delegated lines are closed at machine level and at supervisor without st_sie.
        apply("R4", 16'h0100, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 2'd3);
        apply("R4", 16'h0100, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 2'd1);
        apply("R4", 16'h0100, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 2'd1);
        apply("R4", 16'h0100, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 2'd0);
        // R5: a masked delegated low bit must not hide an open non-delegated bit.
        apply("R5", 16'h0204, 16'hFFFF, 16'h0004, 1'b1, 1'b0, 2'd3);
        apply("R5", 16'h0204, 16'hFFFF, 16'h0200, 1'b0, 1'b1, 2'd1);
        // R9: encoding 2 acts as machine.
        apply("R9", 16'h0010, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 2'd2);
        apply("R9", 16'h0010, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 2'd2);
        apply("R9", 16'h0010, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 2'd2);
        // R7: nothing to take leaves the index at zero.
        apply("R7", 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 2'd3);

        // R8: back-to-back random vectors, one comparison per cycle.
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] rp;
            logic [N-1:0] re;
            rp = N'($urandom) & N'($urandom);
            re = N'($urandom) | N'($urandom);
            apply("R8", rp, re, N'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule